// File: doc/BRIEF.md
# VGA Raster-Op and Bit-Mask Stage

This block is the data-combining step in the write path of a legacy four-plane VGA memory. Each write brings a 32-bit word from the upstream write-mode generator. The stage combines that word with a 32-bit snapshot of the four plane bytes, using one of four two-operand logic functions. The result is then merged with the snapshot under an 8-bit mask. Each mask bit governs the same bit position in all four byte lanes. The registered result is the word that goes to video memory, and it comes with a one-cycle valid pulse.

The snapshot register is filled by read accesses. Every read strobe captures all four plane bytes from memory, and the register holds them until the next read. Software gets a source/destination raster operation by reading a byte and then writing to the same address. One write mode is a pass-through: in that mode the logic function and the mask are both skipped. The same result can be obtained in any other mode by programming the mask to zero, provided the upstream unit presents the snapshot as its data.

Top module: `vga_rop_stage`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `out_data` is 0, and the snapshot register holds 0.
- R2: With `rop_mode` = 2'b00 (copy) and `bit_mask` = 8'hFF in a non-bypass write mode, the output word equals `wr_data`.
- R3: With `rop_mode` = 2'b01, the logic result is the bitwise AND of `wr_data` and the snapshot.
- R4: With `rop_mode` = 2'b10, the logic result is the bitwise OR of `wr_data` and the snapshot.
- R5: With `rop_mode` = 2'b11, the logic result is the bitwise XOR of `wr_data` and the snapshot.
- R6: Mask bit n selects, for bit n of each of the four bytes, the logic result (mask bit 1) or the snapshot bit (mask bit 0).
- R7: When `wr_mode` equals 2'b01, the output equals `wr_data`, whatever the values of `rop_mode` and `bit_mask`. Write modes 2'b00, 2'b10 and 2'b11 use the logic function and the mask.
- R8: With `bit_mask` = 0 in a non-bypass write mode, the output equals the snapshot for every `rop_mode`.
- R9: A pulse on `rd_stb` loads all 32 bits of `rd_data` into the snapshot. The snapshot changes at no other time, and writes leave it unchanged.
- R10: Each cycle with `wr_stb` high produces exactly one `out_valid` pulse one clock later, with the result in `out_data`. `out_data` holds its value between writes.
- R11: When `rd_stb` and `wr_stb` are high in the same cycle, the write combines with the snapshot as it stood before that read. The read's data is used by later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Read access: capture `rd_data` into the snapshot |
| rd_data | input | 32 | Four plane bytes read from memory |
| wr_stb | input | 1 | Write access: combine `wr_data` |
| wr_data | input | 32 | Word from the write-mode generator |
| rop_mode | input | 2 | Logic function: 00 copy, 01 AND, 10 OR, 11 XOR |
| bit_mask | input | 8 | Per-bit select applied to every byte lane |
| wr_mode | input | 2 | Active write mode; 01 is the pass-through mode |
| out_data | output | 32 | Registered word for memory |
| out_valid | output | 1 | One-cycle pulse marking `out_data` as new |

## Verification
The bench builds the block with its default parameters: four 8-bit lanes, a 2-bit write mode, and pass-through mode 1. With these values a single mask pattern such as 8'h0F or 8'h81 shows whether one mask bit reaches the same position in all four lanes. Every write-mode code can be tried, so the bench checks that only one of them bypasses the logic function and the mask. Back-to-back reads and a read in the same cycle as a write show which snapshot each write combines with.

// File: rtl/vga_rop_pkg.sv
// Shared types for the raster-op stage.
// Assumes a 2-bit function code supplied by configuration logic.
package vga_rop_pkg;
    typedef enum logic [1:0] {
        ROP_COPY = 2'b00,
        ROP_AND  = 2'b01,
        ROP_OR   = 2'b10,
        ROP_XOR  = 2'b11
    } rop_op_e;
endpackage

// File: rtl/plane_latch.sv
// Snapshot register for the four plane bytes.
// Loads the whole word on each load strobe and holds it otherwise.
// Assumes the strobe is a single-cycle qualifier synchronous to clk.
module plane_latch #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    // Capture read data on a load strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

    // R9
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(d)));
    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));
endmodule

// File: rtl/rop_alu.sv
// Two-operand logic unit: copy, AND, OR or XOR of the write word and the snapshot.
// Purely combinational; assumes the operands are already aligned.
module rop_alu
    import vga_rop_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  rop_op_e           op,
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] snap,
    output logic [WORD_W-1:0] res
);
    // Select the bitwise function named by op.
    always_comb begin
        case (op)
            ROP_AND: res = src & snap;
            ROP_OR:  res = src | snap;
            ROP_XOR: res = src ^ snap;
            default: res = src;
        endcase
    end
endmodule

// File: rtl/lane_mask_merge.sv
// Per-bit merge of the logic result with the snapshot.
// One mask bit drives the same bit position in every lane; a 1 keeps the logic result.
module lane_mask_merge #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic [LANE_W-1:0] mask,
    input  logic [WORD_W-1:0] alu_word,
    input  logic [WORD_W-1:0] snap_word,
    output logic [WORD_W-1:0] merged
);
    // Replicate the lane mask across all lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] =
            (mask & alu_word[g*LANE_W +: LANE_W]) |
            (~mask & snap_word[g*LANE_W +: LANE_W]);
    end
endmodule

// File: rtl/vga_rop_stage.sv
// Raster-op and bit-mask stage of a four-plane VGA write path.
// Combines each write word with the read snapshot through a logic function and a
// lane-replicated mask, and registers the result with a single-cycle valid pulse.
// Assumes one access per strobe; a write in the same cycle as a read uses the older snapshot.
module vga_rop_stage
    import vga_rop_pkg::*;
#(
    parameter int LANE_W      = 8,
    parameter int LANES       = 4,
    parameter int MODE_W      = 2,
    parameter int BYPASS_MODE = 1,
    localparam int WORD_W     = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        rop_mode,
    input  logic [LANE_W-1:0] bit_mask,
    input  logic [MODE_W-1:0] wr_mode,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid
);
    logic [WORD_W-1:0] snap_q;
    logic [WORD_W-1:0] alu_res;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] final_word;
    logic              bypass;

    plane_latch #(.WORD_W(WORD_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (rd_stb),
        .d     (rd_data),
        .q     (snap_q)
    );

    rop_alu #(.WORD_W(WORD_W)) u_alu (
        .op   (rop_op_e'(rop_mode)),
        .src  (wr_data),
        .snap (snap_q),
        .res  (alu_res)
    );

    lane_mask_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
        .mask      (bit_mask),
        .alu_word  (alu_res),
        .snap_word (snap_q),
        .merged    (merged)
    );

    // Pass-through write mode skips both the logic function and the mask.
    always_comb begin
        bypass     = (wr_mode == MODE_W'(BYPASS_MODE));
        final_word = bypass ? wr_data : merged;
    end

    // Register the result and raise valid for one cycle per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= wr_stb;
            if (wr_stb) out_data <= final_word;
        end
    end

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> out_valid);
    // R10
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> (!out_valid && $stable(out_data)));
    // R7
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_mode == MODE_W'(BYPASS_MODE)) |=> (out_data == $past(wr_data)));
    // R8
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_mode != MODE_W'(BYPASS_MODE) && bit_mask == '0)
            |=> (out_data == $past(snap_q)));
endmodule

// File: tb/vga_rop_stage_tb.sv
`timescale 1ns/1ps
module vga_rop_stage_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic [31:0] rd_data = '0;
    logic        wr_stb = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rop_mode = '0;
    logic [7:0]  bit_mask = '0;
    logic [1:0]  wr_mode = '0;
    logic [31:0] out_data;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] ref_snap = '0;

    always #4 clk = ~clk;

    vga_rop_stage u_dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_data(wr_data), .rop_mode(rop_mode),
        .bit_mask(bit_mask), .wr_mode(wr_mode),
        .out_data(out_data), .out_valid(out_valid)
    );

    function automatic logic [31:0] model(logic [31:0] w, logic [31:0] s,
                                          logic [1:0] op, logic [7:0] m, logic [1:0] wm);
        logic [31:0] a, mm;
        if (wm == 2'b01) return w;
        case (op)
            2'b01: a = w & s;
            2'b10: a = w | s;
            2'b11: a = w ^ s;
            default: a = w;
        endcase
        mm = {4{m}};
        return (a & mm) | (s & ~mm);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(logic [31:0] d);
        @(negedge clk);
        rd_stb = 1'b1; rd_data = d;
        @(negedge clk);
        rd_stb = 1'b0;
        ref_snap = d;
    endtask

    // Issue one write and check the registered result and the valid pulse.
    task automatic wr_chk(string req, logic [31:0] d, logic [1:0] op,
                          logic [7:0] m, logic [1:0] wm);
        logic [31:0] exp;
        exp = model(d, ref_snap, op, m, wm);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d; rop_mode = op; bit_mask = m; wr_mode = wm;
        @(negedge clk);
        wr_stb = 1'b0;
        chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
        chk(req, out_data, exp);
    endtask

    task automatic t_reset;
        chk("R1 valid", {31'b0, out_valid}, 32'd0);
        chk("R1 data", out_data, 32'd0);
        wr_chk("R1 snapshot", 32'hDEAD_BEEF, 2'b00, 8'h00, 2'b00);
    endtask

    task automatic t_copy;
        do_read(32'hA5A5_5A5A);
        wr_chk("R2", 32'h1234_5678, 2'b00, 8'hFF, 2'b00);
        @(negedge clk);
        chk("R10 single pulse", {31'b0, out_valid}, 32'd0);
        chk("R10 hold", out_data, 32'h1234_5678);
        @(negedge clk);
        chk("R10 hold2", out_data, 32'h1234_5678);
    endtask

    task automatic t_logic;
        do_read(32'hF0F0_3C3C);
        wr_chk("R3", 32'hFF00_0FF0, 2'b01, 8'hFF, 2'b00);
        wr_chk("R4", 32'h0F0F_0101, 2'b10, 8'hFF, 2'b10);
        wr_chk("R5", 32'hFFFF_0000, 2'b11, 8'hFF, 2'b11);
    endtask

    task automatic t_mask;
        do_read(32'h1122_3344);
        wr_chk("R6 low nibble", 32'hFFFF_FFFF, 2'b11, 8'h0F, 2'b00);
        wr_chk("R6 edge bits", 32'h0000_0000, 2'b00, 8'h81, 2'b00);
        wr_chk("R6 single", 32'hFFFF_FFFF, 2'b10, 8'h10, 2'b10);
    endtask

    task automatic t_mask_zero;
        do_read(32'hCAFE_F00D);
        for (int op = 0; op < 4; op++)
            wr_chk("R8", 32'h5555_AAAA, op[1:0], 8'h00, 2'b00);
        wr_chk("R8 mode3", 32'h1357_9BDF, 2'b11, 8'h00, 2'b11);
    endtask

    task automatic t_bypass;
        do_read(32'h0F0F_0F0F);
        wr_chk("R7 and", 32'h8899_AABB, 2'b01, 8'h00, 2'b01);
        wr_chk("R7 xor", 32'h7766_5544, 2'b11, 8'h3C, 2'b01);
        wr_chk("R7 mode2 not bypass", 32'h7766_5544, 2'b11, 8'h3C, 2'b10);
    endtask

    task automatic t_latch;
        do_read(32'h0102_0304);
        do_read(32'hA0B0_C0D0);
        wr_chk("R9 last read", 32'hFFFF_FFFF, 2'b00, 8'h00, 2'b00);
        wr_chk("R9 write no load", 32'h1111_1111, 2'b00, 8'hFF, 2'b01);
        wr_chk("R9 still held", 32'h2222_2222, 2'b00, 8'h00, 2'b00);
    endtask

    task automatic t_same_cycle;
        logic [31:0] old_snap;
        do_read(32'h3333_3333);
        old_snap = ref_snap;
        @(negedge clk);
        rd_stb = 1'b1; rd_data = 32'hC3C3_C3C3;
        wr_stb = 1'b1; wr_data = 32'h0F0F_F0F0; rop_mode = 2'b11; bit_mask = 8'hFF; wr_mode = 2'b00;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        chk("R11 old snapshot", out_data, 32'h0F0F_F0F0 ^ old_snap);
        ref_snap = 32'hC3C3_C3C3;
        wr_chk("R11 new snapshot", 32'h0000_0000, 2'b00, 8'h00, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_copy();
        t_logic();
        t_mask();
        t_mask_zero();
        t_bypass();
        t_latch();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule